// File: doc/BRIEF.md
# NAND Flash Device Command Interface

This block models the device side of a small NAND-style flash part. A host drives an 8-bit byte bus with a chip enable, command and address latch strobes, and write and read strobes. The block latches commands, address bytes and data bytes when the write strobe rises. Read data comes back on a separate output byte, and a ready/busy output goes low while a program or erase runs. The storage is a behavioural byte array of whole pages, each with 512 data bytes and 16 spare bytes. The block and page counts are parameters.

A read begins with one of three pointer commands, then one column byte and two row bytes. Every rising edge of the read strobe steps the pointer. When the pointer passes the last byte of a page, it moves to the next page. Programming gathers bytes into a page buffer, and a confirm code commits them. Erase fills a whole block with ones. Status and identification reads use the same output byte. All strobes are sampled in the `clk` domain, so each strobe level must last at least two clock cycles.

Top module: `nandm_dev`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` while `ce_n` is low. It is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and data when both are 0. With `ce_n` high, the write strobe has no effect.
- R2: Commands 00h, 01h and 50h set the read pointer mode. The following address cycles are: one column byte, then two row bytes (low byte first), and the page is the low bits of the row. The start column is the column byte in mode 00h, 256 plus the column byte in mode 01h, and 512 plus the column byte's low 4 bits in mode 50h.
- R3: `dout` shows the array byte at the pointer no later than three clocks after the pointer changes. Each rising edge of `re_n` (with `ce_n` low and the block ready) advances the pointer by one.
- R4: Stepping past column 527 moves to the next page, wrapping after the last page. The column restarts at 0 in modes 00h and 01h, and at 512 in mode 50h.
- R5: 80h, then the address cycles, then data bytes fill the page buffer from the start column. Confirm code 10h writes only the bytes that were loaded, and leaves `ry_by_n` low for exactly 529 cycles. Data bytes past column 527 are dropped.
- R6: Once 80h has been accepted, only 10h and FFh are acted on. Any other command is dropped, and data loading continues.
- R7: 60h, then two row bytes, then D0h sets every byte of the block that holds the addressed page to FFh. `ry_by_n` stays low for exactly 1056 cycles.
- R8: Address cycles beyond the number a command needs are accepted on the bus but change no pointer.
- R9: After 70h, `dout` shows a status byte: bit7 = `wp_n`, bit6 = ready, bit0 = last program or erase failed, all other bits 0. The status byte is accepted while busy and follows the state live.
- R10: If `wp_n` is low at a 10h or D0h confirm, no operation starts and the fail bit is set. If `wp_n` goes low during a program or erase, the operation stops, the block is ready the next cycle, and the fail bit is set.
- R11: Command FFh aborts any operation. It sets the pointer to page 0, column 0, mode 00h, clears the loaded marks of the page buffer and clears the fail bit.
- R12: 90h followed by one address cycle makes `dout` show MAKER_ID (default A5h). After one `re_n` pulse it shows DEVICE_ID (default 3Ch).
- R13: An unlisted command code, and a 10h or D0h that arrives outside its own sequence, leave the pointer and output unchanged.
- R14: While `rst` is high, `dout` is 00h and `ry_by_n` is 1. After reset the pointer is at page 0, column 0 in mode 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we_n | input | 1 | Write strobe, byte taken on rising edge |
| re_n | input | 1 | Read strobe, pointer steps on rising edge |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Command, address or data byte from host |
| dout | output | 8 | Array, status or ID byte to host |
| ry_by_n | output | 1 | High when ready, low while program or erase runs |

## Verification
The bench programs whole and partial pages and then reads from all three pointer modes. It reads across page ends, including the wrap from the last page back to page 0 in spare mode. A pointer that restarted at the wrong column would return a byte from a neighbouring page, and stray writes past column 527 would show up in column 0. It sends a read command in the middle of serial input, and it sends a surplus row byte. A design that obeyed either would load data at the wrong column or read the wrong page. It also drops write protect at a confirm code and in the middle of an erase, and sends a reset during a busy erase, then checks the exact busy lengths, the status bits and the contents that survived.

// File: rtl/nandm_pkg.sv
package nandm_pkg;
  localparam logic [7:0] CMD_READ_LO = 8'h00;
  localparam logic [7:0] CMD_READ_HI = 8'h01;
  localparam logic [7:0] CMD_READ_SP = 8'h50;
  localparam logic [7:0] CMD_SERIN   = 8'h80;
  localparam logic [7:0] CMD_PROG    = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [2:0] {FE_IDLE, FE_READ_A, FE_SERIN, FE_ERASE_A, FE_ID_A} fe_t;
  typedef enum logic [1:0] {JOB_NONE, JOB_PROG, JOB_ERASE} job_t;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} out_t;
endpackage

// File: rtl/nandm_edge.sv
module nandm_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic q;
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b1;
    else     q <= sig;
  end
  assign rise = sig & ~q;
endmodule

// File: rtl/nandm_ram.sv
module nandm_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 528,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nandm_dev.sv
module nandm_dev
  import nandm_pkg::*;
#(
  parameter int DATA_BYTES      = 512,
  parameter int SPARE_BYTES     = 16,
  parameter int BLOCKS          = 2,
  parameter int PAGES_PER_BLOCK = 2,
  parameter int ROW_CYCLES      = 2,
  parameter logic [7:0] MAKER_ID  = 8'hA5,
  parameter logic [7:0] DEVICE_ID = 8'h3C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       ry_by_n
);
  localparam int PB        = DATA_BYTES + SPARE_BYTES;
  localparam int HALF      = DATA_BYTES / 2;
  localparam int PAGES     = BLOCKS * PAGES_PER_BLOCK;
  localparam int ROW_W     = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int PPB_W     = $clog2(PAGES_PER_BLOCK);
  localparam int BLK_BYTES = PAGES_PER_BLOCK * PB;
  localparam int MEM_DEPTH = PAGES * PB;
  localparam int MA_W      = $clog2(MEM_DEPTH);
  localparam int PA_W      = $clog2(PB);
  localparam int COL_W     = $clog2(PB + 1);
  localparam int CNT_W     = $clog2(BLK_BYTES + 1);
  localparam int RW        = 8 * ROW_CYCLES;
  localparam int AC_W      = $clog2(ROW_CYCLES + 2);

  logic we_rise, re_rise;
  nandm_edge u_we (.clk(clk), .rst(rst), .sig(we_n), .rise(we_rise));
  nandm_edge u_re (.clk(clk), .rst(rst), .sig(re_n), .rise(re_rise));

  logic cmd_hit, addr_hit, data_hit, rd_hit, rst_cmd, busy;
  assign cmd_hit  = we_rise & ~ce_n & cle & ~ale;
  assign addr_hit = we_rise & ~ce_n & ale & ~cle;
  assign data_hit = we_rise & ~ce_n & ~cle & ~ale;
  assign rd_hit   = re_rise & ~ce_n;
  assign rst_cmd  = cmd_hit && (din == CMD_RESET);

  fe_t                fe;
  job_t               job;
  out_t               outsel;
  logic [1:0]         rmode;
  logic [COL_W-1:0]   col;
  logic [RW-1:0]      row;
  logic [AC_W-1:0]    addr_cnt, addr_need;
  logic [CNT_W-1:0]   cnt;
  logic [PB-1:0]      written;
  logic               fail, id_sel;
  logic [ROW_W-1:0]   page;

  assign busy    = (job != JOB_NONE);
  assign ry_by_n = ~busy;
  assign page    = row[ROW_W-1:0];

  always_comb begin
    case (fe)
      FE_READ_A, FE_SERIN: addr_need = AC_W'(ROW_CYCLES + 1);
      FE_ERASE_A:          addr_need = AC_W'(ROW_CYCLES);
      FE_ID_A:             addr_need = AC_W'(1);
      default:             addr_need = '0;
    endcase
  end

  logic [COL_W-1:0] start_col;
  always_comb begin
    case (rmode)
      2'd1:    start_col = COL_W'(HALF) + COL_W'(din);
      2'd2:    start_col = COL_W'(DATA_BYTES) + COL_W'(din & 8'(SPARE_BYTES - 1));
      default: start_col = COL_W'(din);
    endcase
  end

  logic load_data;
  assign load_data = data_hit && !busy && fe == FE_SERIN && addr_cnt == addr_need && col < COL_W'(PB);

  always_ff @(posedge clk) begin
    if (rst) begin
      fe <= FE_IDLE; job <= JOB_NONE; outsel <= OUT_ARRAY; rmode <= 2'd0;
      col <= '0; row <= '0; addr_cnt <= '0; cnt <= '0; written <= '0;
      fail <= 1'b0; id_sel <= 1'b0;
    end else begin
      if (busy) begin
        if (!wp_n) begin
          job <= JOB_NONE; fail <= 1'b1;
        end else if (job == JOB_PROG) begin
          if (cnt == CNT_W'(PB)) job <= JOB_NONE;
          else cnt <= cnt + 1'b1;
        end else begin
          if (cnt == CNT_W'(BLK_BYTES - 1)) job <= JOB_NONE;
          else cnt <= cnt + 1'b1;
        end
      end
      if (cmd_hit) begin
        if (din == CMD_RESET) begin
          job <= JOB_NONE; fe <= FE_IDLE; rmode <= 2'd0; col <= '0; row <= '0;
          addr_cnt <= '0; written <= '0; fail <= 1'b0; outsel <= OUT_ARRAY;
        end else if (fe == FE_SERIN) begin
          if (din == CMD_PROG) begin
            fe <= FE_IDLE;
            if (wp_n) begin job <= JOB_PROG; cnt <= '0; fail <= 1'b0; end
            else fail <= 1'b1;
          end
        end else if (din == CMD_STATUS) begin
          outsel <= OUT_STATUS;
        end else if (!busy) begin
          case (din)
            CMD_READ_LO: begin rmode <= 2'd0; fe <= FE_READ_A; addr_cnt <= '0; outsel <= OUT_ARRAY; end
            CMD_READ_HI: begin rmode <= 2'd1; fe <= FE_READ_A; addr_cnt <= '0; outsel <= OUT_ARRAY; end
            CMD_READ_SP: begin rmode <= 2'd2; fe <= FE_READ_A; addr_cnt <= '0; outsel <= OUT_ARRAY; end
            CMD_SERIN:   begin fe <= FE_SERIN; addr_cnt <= '0; written <= '0; end
            CMD_ERASE:   begin fe <= FE_ERASE_A; addr_cnt <= '0; end
            CMD_IDENT:   begin fe <= FE_ID_A; addr_cnt <= '0; outsel <= OUT_ID; id_sel <= 1'b0; end
            CMD_CONFIRM: begin
              if (fe == FE_ERASE_A && addr_cnt == addr_need) begin
                fe <= FE_IDLE;
                if (wp_n) begin job <= JOB_ERASE; cnt <= '0; fail <= 1'b0; end
                else fail <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      if (addr_hit && !busy && addr_cnt < addr_need) begin
        addr_cnt <= addr_cnt + 1'b1;
        if ((fe == FE_READ_A || fe == FE_SERIN) && addr_cnt == '0) col <= start_col;
        else if (fe != FE_ID_A) row <= (row >> 8) | (RW'(din) << (RW - 8));
      end
      if (load_data) begin
        written[col[PA_W-1:0]] <= 1'b1;
        col <= col + 1'b1;
      end
      if (rd_hit && !busy) begin
        if (outsel == OUT_ID) id_sel <= ~id_sel;
        else if (outsel == OUT_ARRAY && fe != FE_SERIN) begin
          if (col >= COL_W'(PB - 1)) begin
            row[ROW_W-1:0] <= page + 1'b1;
            col <= (rmode == 2'd2) ? COL_W'(DATA_BYTES) : '0;
          end else col <= col + 1'b1;
        end
      end
    end
  end

  // page buffer: filled by serial input, drained by the commit loop
  logic [PA_W-1:0] pb_raddr;
  logic [7:0]      pb_q;
  logic            stage_we;
  logic [PA_W-1:0] stage_col;
  assign pb_raddr = (cnt < CNT_W'(PB)) ? cnt[PA_W-1:0] : '0;

  nandm_ram #(.W(8), .DEPTH(PB)) u_pbuf (
    .clk(clk), .we(load_data), .waddr(col[PA_W-1:0]), .wdata(din),
    .raddr(pb_raddr), .rdata(pb_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_we <= 1'b0; stage_col <= '0;
    end else begin
      stage_we  <= (job == JOB_PROG) && wp_n && !rst_cmd &&
                   (cnt < CNT_W'(PB)) && written[pb_raddr];
      stage_col <= pb_raddr;
    end
  end

  // array: one write port shared by commit and erase, one read port for the pointer
  logic             mem_we;
  logic [MA_W-1:0]  mem_wa, mem_ra;
  logic [7:0]       mem_wd, mem_q;
  logic [ROW_W-1:0] blk_page;
  logic [PA_W-1:0]  rd_col;

  assign blk_page = (page >> PPB_W) << PPB_W;
  assign rd_col   = (col < COL_W'(PB)) ? col[PA_W-1:0] : '0;
  assign mem_ra   = MA_W'(page) * MA_W'(PB) + MA_W'(rd_col);
  assign mem_we   = ((job == JOB_ERASE) && wp_n && !rst_cmd) || stage_we;
  assign mem_wa   = (job == JOB_ERASE) ? MA_W'(blk_page) * MA_W'(PB) + MA_W'(cnt)
                                       : MA_W'(page) * MA_W'(PB) + MA_W'(stage_col);
  assign mem_wd   = (job == JOB_ERASE) ? 8'hFF : pb_q;

  nandm_ram #(.W(8), .DEPTH(MEM_DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(mem_ra), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 8'h00;
    else begin
      case (outsel)
        OUT_STATUS: dout <= {wp_n, ~busy, 5'b0, fail};
        OUT_ID:     dout <= id_sel ? DEVICE_ID : MAKER_ID;
        default:    dout <= mem_q;
      endcase
    end
  end

  a_r5_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  a_r6_serin_locked: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && fe == FE_SERIN && din != CMD_PROG && din != CMD_RESET)
    |=> (fe == FE_SERIN && job == JOB_NONE));
  a_r8_surplus_addr: assert property (@(posedge clk) disable iff (rst)
    (addr_hit && !busy && !cmd_hit && addr_cnt >= addr_need) |=> ($stable(row) && $stable(col)));
  a_r4_page_step: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !busy && !we_rise && outsel == OUT_ARRAY && fe != FE_SERIN && col == COL_W'(PB - 1))
    |=> (page == ROW_W'($past(page) + 1'b1)) &&
        (col == ((rmode == 2'd2) ? COL_W'(DATA_BYTES) : COL_W'(0))));
  a_r10_wp_abort: assert property (@(posedge clk) disable iff (rst)
    (busy && !wp_n && !rst_cmd) |=> (ry_by_n && fail));
  a_r11_reset_cmd: assert property (@(posedge clk) disable iff (rst)
    rst_cmd |=> (ry_by_n && written == '0 && col == '0 && !fail));
endmodule

// File: tb/sim_nandm_dev.sv
module sim_nandm_dev;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic ry_by_n;

  always #10 clk = ~clk;

  nandm_dev u0 (.clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
                .re_n(re_n), .wp_n(wp_n), .din(din), .dout(dout), .ry_by_n(ry_by_n));

  int checks = 0, errors = 0, bcnt = 0, cyc = 0;
  logic [7:0] model [4][528];

  // vector fields: command, column byte, page, number of bytes read
  localparam logic [31:0] VECS [8] = '{
    {8'h00, 8'd5,   8'd1, 8'd3},  {8'h01, 8'd3,   8'd1, 8'd3},
    {8'h50, 8'd2,   8'd1, 8'd3},  {8'h01, 8'd254, 8'd1, 8'd3},
    {8'h01, 8'd255, 8'd0, 8'd18}, {8'h50, 8'd15,  8'd3, 8'd3},
    {8'h00, 8'd9,   8'd2, 8'd5},  {8'h00, 8'd0,   8'd3, 8'd1}
  };

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'(p * 53 + c * 7 + 1);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] v, input logic ce);
    @(negedge clk); cle = c; ale = a; din = v; ce_n = ce; we_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] v); bus_wr(1'b1, 1'b0, v, 1'b0); endtask
  task automatic adr(input logic [7:0] v); bus_wr(1'b0, 1'b1, v, 1'b0); endtask
  task automatic dat(input logic [7:0] v); bus_wr(1'b0, 1'b0, v, 1'b0); endtask
  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic rpulse();
    @(negedge clk); re_n = 1'b0;
    repeat (2) @(negedge clk); re_n = 1'b1;
    settle();
  endtask
  task automatic wait_ready();
    @(negedge clk);
    while (!ry_by_n) @(negedge clk);
  endtask
  task automatic seek(input logic [7:0] c, input logic [7:0] col, input logic [7:0] pg);
    cmd(c); adr(col); adr(pg); adr(8'h00); settle();
  endtask

  always @(negedge clk) if (!ry_by_n) bcnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 528; c++) model[p][c] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R14 dout in reset", dout, 8'h00);
    chk("R14 ready in reset", {7'd0, ry_by_n}, 8'h01);
    rst = 1'b0; ce_n = 1'b0;
    cmd(8'h70); settle();
    chk("R14 R9 status after reset", dout, 8'hC0);

    // full page program, page 1
    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int c = 0; c < 528; c++) begin dat(pat(1, c)); model[1][c] = pat(1, c); end
    bcnt = 0; cmd(8'h10); wait_ready();
    chk("R5 program busy length lo", 8'(bcnt), 8'(529));
    chk("R5 program busy length hi", 8'(bcnt >> 8), 8'(529 >> 8));

    // partial program with a dropped read command inside, page 2
    cmd(8'h80); adr(8'd10); adr(8'h02); adr(8'h00);
    dat(8'hA1); cmd(8'h50); dat(8'hA2); dat(8'hA3); cmd(8'h10); wait_ready();
    model[2][10] = 8'hA1; model[2][11] = 8'hA2; model[2][12] = 8'hA3;

    // spare mode program with an overflow byte, page 3
    cmd(8'h50); cmd(8'h80); adr(8'd14); adr(8'h03); adr(8'h00);
    dat(8'h5A); dat(8'h5B); dat(8'h5C); cmd(8'h10); wait_ready();
    model[3][526] = 8'h5A; model[3][527] = 8'h5B;

    // table of reads: R2 start column, R3 streaming, R4 page crossing, R5 R6 contents
    for (int i = 0; i < 8; i++) begin
      logic [7:0] vc, vcol, vpg, vn;
      int p, c;
      {vc, vcol, vpg, vn} = VECS[i];
      p = int'(vpg);
      c = (vc == 8'h00) ? int'(vcol) : (vc == 8'h01) ? 256 + int'(vcol) : 512 + int'(vcol[3:0]);
      seek(vc, vcol, vpg);
      for (int k = 0; k < int'(vn); k++) begin
        chk($sformatf("R2 R3 R4 R5 R6 vec%0d byte%0d", i, k), dout, model[p][c]);
        rpulse();
        if (c == 527) begin p = (p + 1) % 4; c = (vc == 8'h50) ? 512 : 0; end
        else c++;
      end
    end

    // R8 surplus row byte would move the pointer to page 0 if obeyed
    cmd(8'h00); adr(8'd7); adr(8'h01); adr(8'h00); adr(8'h03); settle();
    chk("R8 surplus address ignored", dout, model[1][7]);

    // R13 unlisted and out-of-sequence codes, R1 chip enable
    cmd(8'h33); cmd(8'h10); cmd(8'hD0); settle();
    chk("R13 dropped codes keep output", dout, model[1][7]);
    rpulse();
    chk("R13 pointer still steps", dout, model[1][8]);
    bus_wr(1'b1, 1'b0, 8'h90, 1'b1); settle();
    chk("R1 ce_n high ignores write", dout, model[1][8]);
    rpulse();
    chk("R1 pointer intact after ce_n high", dout, model[1][9]);

    // R12 identification
    cmd(8'h90); adr(8'h00); settle();
    chk("R12 maker byte", dout, 8'hA5);
    rpulse();
    chk("R12 device byte", dout, 8'h3C);

    // R7 erase of block 0 addressed through page 1, R9 status while busy
    cmd(8'h60); adr(8'h01); adr(8'h00);
    bcnt = 0; cmd(8'hD0); cmd(8'h70); settle();
    chk("R9 status while busy", dout, 8'h80);
    wait_ready();
    chk("R7 erase busy length lo", 8'(bcnt), 8'(1056));
    chk("R7 erase busy length hi", 8'(bcnt >> 8), 8'(1056 >> 8));
    settle();
    chk("R9 status follows ready", dout, 8'hC0);
    for (int c = 0; c < 528; c++) begin model[0][c] = 8'hFF; model[1][c] = 8'hFF; end
    seek(8'h00, 8'd5, 8'h01);
    chk("R7 erased byte", dout, 8'hFF);
    seek(8'h00, 8'd10, 8'h02);
    chk("R7 other block intact", dout, 8'hA1);

    // R10 write protect at confirm
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h55);
    wp_n = 1'b0; cmd(8'h10); settle();
    chk("R10 no start under protect", {7'd0, ry_by_n}, 8'h01);
    cmd(8'h70); settle();
    chk("R10 status fail protected", dout, 8'h41);
    wp_n = 1'b1; settle();
    chk("R10 status fail unprotected", dout, 8'hC1);
    seek(8'h00, 8'h00, 8'h00);
    chk("R10 array unchanged", dout, 8'hFF);

    // R10 protect dropped during erase of block 1
    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    repeat (20) @(negedge clk);
    wp_n = 1'b0; repeat (2) @(negedge clk);
    chk("R10 abort frees device", {7'd0, ry_by_n}, 8'h01);
    cmd(8'h70); settle();
    chk("R10 abort status", dout, 8'h41);
    wp_n = 1'b1;
    seek(8'h50, 8'd14, 8'h03);
    chk("R10 abort stopped early", dout, 8'h5A);

    // R11 reset during busy erase
    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    repeat (10) @(negedge clk);
    cmd(8'hFF); settle();
    chk("R11 reset aborts busy", {7'd0, ry_by_n}, 8'h01);
    cmd(8'h70); settle();
    chk("R11 reset clears fail", dout, 8'hC0);

    // R11 buffer marks cleared by reset
    cmd(8'h80); adr(8'h03); adr(8'h00); adr(8'h00); dat(8'h77); cmd(8'hFF);
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); dat(8'h66); cmd(8'h10); wait_ready();
    model[0][0] = 8'h66;
    seek(8'h00, 8'h00, 8'h00);
    chk("R11 new byte programmed", dout, 8'h66);
    rpulse(); rpulse(); rpulse();
    chk("R11 stale buffer byte dropped", dout, 8'hFF);

    // R11 pointer returns to page 0 column 0
    seek(8'h00, 8'd9, 8'h03);
    cmd(8'hFF); settle();
    chk("R11 pointer cleared", dout, model[0][0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule